// File: doc/BRIEF.md
# Watchdog Kick Toggle Extender

This block sits between a processor's software watchdog kick and the kick pin of an external hardware watchdog. Software signals that it is alive by flipping a single input level. The block does not pass that level to the pin. It drives the pin from its own toggle register, which flips once on every millisecond strobe from a shared timebase.

Every change of the software input, rising or falling, re-arms an extension counter to 2^(W-1) strobes. The pin keeps toggling until that counter has been worn down by strobes. Software can therefore stop kicking for about 2^(W-1) ms, which is roughly 8 s at the default W of 14, for example while it reloads, and the board is not reset. When the counter reaches zero the pin freezes at its last level, and the external watchdog is then free to fire.

The block runs in the management clock domain. It is held in reset until that domain's clock is stable. The software input is expected to arrive already synchronised to this clock.

Top module: `wdog_kick_extender`

## Requirements
- R1: While `rst_n` is low, `wdo` is 0 and the extension counter is empty. After reset, strobes make no toggles until the first change of `kick_in`.
- R2: A change of `kick_in` is any difference between its present value and its value at the previous clock edge, and the reference value after reset is 0. Both rising and falling changes reload the extension counter to 2^(W-1).
- R3: On a clock edge where `tick_ms` is 1 and the counter is non-zero, `wdo` inverts. The new level is visible after that edge.
- R4: The counter drops by one on each strobe while it is non-zero. Without a strobe or a change it holds its value.
- R5: After the last change of `kick_in`, exactly 2^(W-1) later strobes toggle `wdo`. After that, `wdo` holds its last level.
- R6: If a change of `kick_in` and a strobe fall on the same edge, the counter reloads instead of decrementing. `wdo` still toggles on that strobe, so 2^(W-1)+1 toggles follow in total.
- R7: `wdo` never changes on an edge where `tick_ms` is 0, whatever `kick_in` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Management domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_ms | input | 1 | One-cycle millisecond strobe from the shared timebase |
| kick_in | input | 1 | Software-driven watchdog kick level |
| wdo | output | 1 | Toggling kick to the external watchdog pin |

## Verification
The properties assume that `kick_in` is already synchronous to `clk`, so a change is a clean level difference from one edge to the next. They also assume that `tick_ms` comes from a timebase, but they do not require the strobe to be a single cycle: every high cycle counts as a strobe. The stimulus changes both inputs only on the falling clock edge and issues strobes as single high cycles separated by idle cycles. It places software changes both between strobes and exactly on a strobe, so that the reload-over-decrement priority is exercised.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  // Strobes granted by one software change for a counter of width w
  function automatic int unsigned ext_span(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

  // What the extension counter does on a given edge
  typedef enum logic [1:0] {
    EXT_HOLD   = 2'd0,
    EXT_COUNT  = 2'd1,
    EXT_RELOAD = 2'd2
  } ext_evt_e;

endpackage

// File: rtl/wdk_kick_edge.sv
module wdk_kick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_in,
  output logic kick_chg
);

  logic kick_q;
  logic kick_d;
  logic kick_en;

  always_comb begin
    kick_en  = 1'b1;
    kick_d   = kick_in;
    kick_chg = kick_in ^ kick_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_q <= 1'b0;
    end else if (kick_en) begin
      kick_q <= kick_d;
    end
  end

endmodule

// File: rtl/wdk_ext_counter.sv
module wdk_ext_counter
  import wdk_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reload,
  output logic [W-1:0] cnt,
  output logic         active
);

  localparam int unsigned SPAN   = ext_span(W);
  localparam logic [W-1:0] SPAN_V = W'(SPAN);
  localparam logic [W-1:0] ONE_V  = W'(1);

  ext_evt_e     evt;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    active = (cnt_q != '0);
    if (reload) begin
      evt = EXT_RELOAD;
    end else if (tick && active) begin
      evt = EXT_COUNT;
    end else begin
      evt = EXT_HOLD;
    end
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    case (evt)
      EXT_RELOAD: begin
        cnt_en = 1'b1;
        cnt_d  = SPAN_V;
      end
      EXT_COUNT: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - ONE_V;
      end
      default: begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/wdk_toggle_reg.sv
module wdk_toggle_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  output logic wdo
);

  logic tog_q;
  logic tog_d;
  logic tog_en;

  always_comb begin
    tog_en = tick & arm;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

  assign wdo = tog_q;

endmodule

// File: rtl/wdog_kick_extender.sv
module wdog_kick_extender #(
  parameter int unsigned W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic kick_in,
  output logic wdo
);

  logic         kick_chg;
  logic [W-1:0] ext_cnt;
  logic         ext_active;
  logic         tog_arm;

  wdk_kick_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick_in  (kick_in),
    .kick_chg (kick_chg)
  );

  wdk_ext_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_ms),
    .reload (kick_chg),
    .cnt    (ext_cnt),
    .active (ext_active)
  );

  // A change on a strobe edge still earns a toggle
  assign tog_arm = ext_active | kick_chg;

  wdk_toggle_reg u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_ms),
    .arm   (tog_arm),
    .wdo   (wdo)
  );

endmodule

// File: rtl/wdog_kick_extender_chk.sv
module wdog_kick_extender_chk
  import wdk_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_ms,
  input logic         wdo,
  input logic         kick_chg,
  input logic [W-1:0] ext_cnt
);

  localparam logic [W-1:0] SPAN_V = W'(ext_span(W));

  // R1: the output sits low while reset is asserted
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (wdo == 1'b0);
    end
  end

  // R2: any software change refills the counter
  assert_reload_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    kick_chg |=> (ext_cnt == SPAN_V));

  // R3: a strobe with an armed counter flips the pin
  assert_tick_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ms && (ext_cnt != '0)) |=> (wdo != $past(wdo)));

  // R4: a plain strobe wears the counter down by one
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ms && !kick_chg && (ext_cnt != '0)) |=> (ext_cnt == $past(ext_cnt) - W'(1)));

  // R4: no strobe and no change keeps the counter
  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_ms && !kick_chg) |=> $stable(ext_cnt));

  // R5: an exhausted counter with no change freezes the pin
  assert_idle_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_cnt == '0) && !kick_chg) |=> $stable(wdo));

  // R6: a change on a strobe both reloads and toggles
  assert_same_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ms && kick_chg) |=> ((wdo != $past(wdo)) && (ext_cnt == SPAN_V)));

  // R7: the pin moves only on strobe edges
  assert_no_tick_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_ms |=> $stable(wdo));

endmodule

bind wdog_kick_extender wdog_kick_extender_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_ms  (tick_ms),
  .wdo      (wdo),
  .kick_chg (kick_chg),
  .ext_cnt  (ext_cnt)
);

// File: tb/wdog_kick_extender_test.sv
`timescale 1ns/1ps
module wdog_kick_extender_test;

  localparam int W    = 6;
  localparam int FULL = 1 << (W - 1);

  logic clk;
  logic rst_n;
  logic tick_ms;
  logic kick_in;
  logic wdo;

  int    checks;
  int    failures;
  int    trans;
  logic  last_wdo;
  string cur_req;
  bit    done;

  // behavioural reference
  int   m_left;
  logic m_prev;
  logic m_out;

  wdog_kick_extender #(.W(W)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_ms (tick_ms),
    .kick_in (kick_in),
    .wdo     (wdo)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0;
      m_prev = 1'b0;
      m_out  = 1'b0;
    end else begin
      bit changed;
      changed = (kick_in != m_prev);
      m_prev  = kick_in;
      if (tick_ms && (m_left > 0 || changed)) m_out = ~m_out;
      if (changed) m_left = FULL;
      else if (tick_ms && m_left > 0) m_left = m_left - 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (wdo !== m_out) begin
        failures++;
        $display("FAIL %s per-cycle wdo actual=%b expected=%b t=%0t", cur_req, wdo, m_out, $time);
      end
      if (wdo !== last_wdo) trans++;
      last_wdo = wdo;
    end
  end

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic k);
    @(negedge clk);
    tick_ms = t;
    kick_in = k;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1, kick_in);
      for (int g = 0; g < gap; g++) step(1'b0, kick_in);
    end
  endtask

  task automatic settle();
    step(1'b0, kick_in);
    @(negedge clk);
    #1;
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; trans = 0; last_wdo = 1'b0;
    cur_req = "R1";
    tick_ms = 1'b0; kick_in = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check_int("R1", "wdo in reset", int'(wdo), 0);
    rst_n = 1'b1;

    // R1: strobes without any change give no kicks
    ticks(10, 2);
    settle();
    check_int("R1", "toggles before first change", trans, 0);

    // R5 and R3: rising change between strobes, full window
    cur_req = "R5";
    step(1'b0, 1'b1);
    settle(); trans = 0;
    ticks(FULL + 5, 2);
    settle();
    check_int("R5", "toggles after rising change", trans, FULL);

    // R2: falling change, then a rising change mid-window reloads
    cur_req = "R2";
    step(1'b0, 1'b0);
    settle(); trans = 0;
    ticks(10, 1);
    settle();
    check_int("R2", "toggles after falling change", trans, 10);
    step(1'b0, 1'b1);
    settle(); trans = 0;
    ticks(FULL + 3, 2);
    settle();
    check_int("R2", "toggles after mid-window reload", trans, FULL);

    // R6: change lands on a strobe
    cur_req = "R6";
    settle(); trans = 0;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    ticks(FULL + 4, 2);
    settle();
    check_int("R6", "toggles with change on strobe", trans, FULL + 1);

    // R7: no strobes while software toggles busily
    cur_req = "R7";
    settle(); trans = 0;
    for (int i = 0; i < 16; i++) begin
      step(1'b0, ~kick_in);
      step(1'b0, kick_in);
      step(1'b0, kick_in);
    end
    settle();
    check_int("R7", "toggles with no strobe", trans, 0);

    // R4: sparse strobes count one each after the last change
    cur_req = "R4";
    trans = 0;
    ticks(7, 7);
    settle();
    check_int("R4", "toggles on sparse strobes", trans, 7);
    ticks(FULL, 1);
    settle();
    check_int("R4", "toggles over remaining window", trans, FULL);

    // R1: reset in the middle of a window clears it
    cur_req = "R1";
    step(1'b0, ~kick_in);
    ticks(5, 1);
    settle();
    rst_n = 1'b0;
    kick_in = 1'b0;
    @(negedge clk);
    #1;
    check_int("R1", "wdo after mid-window reset", int'(wdo), 0);
    rst_n = 1'b1;
    settle(); trans = 0;
    ticks(12, 2);
    settle();
    check_int("R1", "toggles after reset without change", trans, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule